// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block is a clock-sampled model of a digitally programmed delay path. A one-bit input stream is sampled on a fast clock, and each clock period stands for one fine delay step. The output reproduces the input after a fixed pipeline latency plus a number of steps set by a 7-bit tap code. Four clock steps make one unit element, so the two lowest code bits act as a quarter and a half of a unit element.

The delay is built from shift-register segments with binary weights of 1, 2, 4, 8, 16, 32 and 64 cycles. Each code bit either switches its segment into the path or bypasses it through a 2:1 multiplexer. A max-override input selects every segment and adds one more single-cycle segment. The delay therefore steps from 127 cycles at the all-ones code to 128 cycles, and it never decreases.

An inhibit input forces the output low at the output register only, so data already in the line keeps moving. The latched tap code is supplied from outside the block. A change of code while data is in flight may drop or repeat samples at segment boundaries, so users change the code only after the line has drained.

Top module: `prog_delay_line`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, `dout` is 0 and every delay stage is empty. A pulse that was inside the line when reset came never appears on `dout`.
- R2: With `tap_code` = 0 and `force_max` low, `din` reaches `dout` after exactly BASE_LAT (default 2) clock cycles. A value present on `din` in cycle j is seen on `dout` in cycle j+BASE_LAT.
- R3: With `force_max` low, the delay is BASE_LAT + `tap_code` cycles, with `tap_code` read as an unsigned binary number. Bit i adds 2^i cycles, and a stream of several bits keeps its shape.
- R4: The delay grows strictly with the code. The all-ones code (127) gives BASE_LAT + 127 cycles.
- R5: With `force_max` high, the delay is BASE_LAT + 128 cycles whatever `tap_code` holds. That is one cycle more than the all-ones code.
- R6: A high `inhibit` sampled at a clock edge drives `dout` to 0 after that edge. With `inhibit` low, `dout` follows the delayed stream.
- R7: `inhibit` does not disturb data inside the line. A pulse that is in flight while `inhibit` is high appears at its normal time if `inhibit` is low by then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one period is one fine step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Input bit stream |
| tap_code | input | 7 | Binary delay code (bit 0 = 1 cycle ... bit 6 = 64 cycles) |
| force_max | input | 1 | Selects all segments plus one extra cycle |
| inhibit | input | 1 | High forces `dout` low |
| dout | output | 1 | Delayed bit stream |

## Verification
The max-override and the inhibit can act on the same output cycle. The bench sends a pulse through the line with `force_max` high and raises `inhibit` for exactly the edge at which the pulse is due at the output. It expects `dout` to stay low through that cycle and the next one. It then repeats the pulse with `inhibit` low and expects it to arrive in cycle 130. A second case overlaps `inhibit` with a pulse that is still in flight and expects the pulse to emerge on time, which shows that the gating acts only at the output.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int unsigned DLY_CODE_W   = 7;
  localparam int unsigned DLY_BASE_LAT = 2;
endpackage

// File: rtl/dly_rst_sync.sv
module dly_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dly_segment.sv
module dly_segment #(
  parameter int unsigned LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic seg_in,
  output logic seg_out
);
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;

  always_comb begin
    sr_d[0] = seg_in;
    for (int i = 1; i < int'(LEN); i++) sr_d[i] = sr_q[i-1];
  end

  // Shift only while the segment is in the path (clock enable = sel).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr_q <= '0;
    else if (sel) sr_q <= sr_d;
  end

  assign seg_out = sel ? sr_q[LEN-1] : seg_in;

  // R3: a selected segment takes in the incoming sample
  a_r3_seg_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (sr_q[0] == $past(seg_in)));

  // R3: a bypassed segment keeps its contents frozen
  a_r3_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(sr_q));
endmodule

// File: rtl/dly_chain.sv
module dly_chain #(
  parameter int unsigned CODE_W = dly_pkg::DLY_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tap_code,
  input  logic              force_max,
  input  logic              chain_in,
  output logic              chain_out
);
  localparam int unsigned N_LINK = CODE_W + 2;

  logic [CODE_W-1:0] code_eff;
  logic [N_LINK-1:0] link;

  always_comb begin
    code_eff = force_max ? {CODE_W{1'b1}} : tap_code;
  end

  assign link[0] = chain_in;

  for (genvar g = 0; g < int'(CODE_W); g++) begin : g_seg
    dly_segment #(.LEN(1 << g)) u_seg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (code_eff[g]),
      .seg_in (link[g]),
      .seg_out(link[g+1])
    );
  end

  // One extra step past the all-ones code keeps the delay monotonic.
  dly_segment #(.LEN(1)) u_seg_max (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (force_max),
    .seg_in (link[CODE_W]),
    .seg_out(link[CODE_W+1])
  );

  assign chain_out = link[N_LINK-1];
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int unsigned CODE_W   = dly_pkg::DLY_CODE_W,
  parameter int unsigned BASE_LAT = dly_pkg::DLY_BASE_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [CODE_W-1:0] tap_code,
  input  logic              force_max,
  input  logic              inhibit,
  output logic              dout
);
  localparam int unsigned IN_STG = BASE_LAT - 1;

  logic rst_sync_n;
  logic chain_in;
  logic chain_out;
  logic dout_q;
  logic dout_d;

  dly_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  if (IN_STG == 0) begin : g_no_inpipe
    assign chain_in = din;
  end else begin : g_inpipe
    logic [IN_STG-1:0] pipe_q;
    logic [IN_STG-1:0] pipe_d;

    always_comb begin
      pipe_d[0] = din;
      for (int i = 1; i < int'(IN_STG); i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) pipe_q <= '0;
      else             pipe_q <= pipe_d;
    end

    assign chain_in = pipe_q[IN_STG-1];
  end

  dly_chain #(.CODE_W(CODE_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tap_code (tap_code),
    .force_max(force_max),
    .chain_in (chain_in),
    .chain_out(chain_out)
  );

  always_comb begin
    dout_d = inhibit ? 1'b0 : chain_out;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dout_q <= 1'b0;
    else             dout_q <= dout_d;
  end

  assign dout = dout_q;

  // R6: inhibit sampled high gives a low output after the edge
  a_r6_inhibit_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inhibit |=> !dout);

  // R2: with every segment bypassed the output trails the input pipe by one edge
  a_r2_zero_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!inhibit && !force_max && (tap_code == '0)) |=> (dout == $past(chain_in)));
endmodule

// File: tb/prog_delay_line_test.sv
`timescale 1ns/1ps
module prog_delay_line_test;
  localparam int CODE_W = 7;
  localparam int LAT0   = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             din;
  logic [CODE_W-1:0] tap_code;
  logic             force_max;
  logic             inhibit;
  logic             dout;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  prog_delay_line #(.CODE_W(CODE_W), .BASE_LAT(LAT0)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .tap_code(tap_code),
    .force_max(force_max), .inhibit(inhibit), .dout(dout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  // Single-cycle pulse on din; inhibit is high at edges inh_lo..inh_hi.
  // exp_first < 0 means no high output is expected.
  task automatic pulse_run(input int code, input bit fmax, input int inh_lo,
                           input int inh_hi, input int exp_first, input string req);
    int first_hi;
    int n_hi;
    first_hi = -1;
    n_hi = 0;
    tap_code = code[CODE_W-1:0];
    force_max = fmax;
    inhibit = 1'b0;
    idle(140);
    din = 1'b1;
    inhibit = (inh_lo <= 1 && 1 <= inh_hi);
    for (int n = 1; n <= 140; n++) begin
      @(negedge clk);
      din = 1'b0;
      if (dout) begin
        n_hi++;
        if (first_hi < 0) first_hi = n;
      end
      inhibit = (inh_lo <= n + 1 && n + 1 <= inh_hi);
    end
    inhibit = 1'b0;
    chk(first_hi == exp_first, req, first_hi, exp_first);
    chk(n_hi == (exp_first < 0 ? 0 : 1), {req, " width"}, n_hi, (exp_first < 0 ? 0 : 1));
  endtask

  initial begin
    rst_n = 1'b0;
    din = 1'b0;
    tap_code = '0;
    force_max = 1'b0;
    inhibit = 1'b0;
    idle(4);
    chk(dout == 1'b0, "R1 reset low", dout, 0);
    rst_n = 1'b1;
    idle(4);
    chk(dout == 1'b0, "R1 after release", dout, 0);

    // R2 / R3 / R4: every code, latency is LAT0 + code
    for (int c = 0; c < 128; c++)
      pulse_run(c, 1'b0, -1, -1, LAT0 + c, (c == 0) ? "R2 zero code" :
                (c == 127) ? "R4 all ones" : "R3 code sweep");

    // R5: force_max overrides any code
    pulse_run(0,   1'b1, -1, -1, LAT0 + 128, "R5 max over code 0");
    pulse_run(5,   1'b1, -1, -1, LAT0 + 128, "R5 max over code 5");
    pulse_run(127, 1'b1, -1, -1, LAT0 + 128, "R5 max over code 127");

    // R6 with R5: inhibit at the very edge the pulse is due
    pulse_run(3, 1'b1, LAT0 + 128, LAT0 + 128, -1, "R6 inhibit at max emergence");
    // R7: inhibit while the pulse is still inside the line
    pulse_run(20, 1'b0, 2, 15, LAT0 + 20, "R7 inflight survives inhibit");

    // R3: multi-bit stream keeps its shape
    begin
      bit [7:0] pat;
      int got;
      pat = 8'b1011_0010;
      got = 0;
      tap_code = 7'd9;
      idle(140);
      for (int n = 0; n < 8 + LAT0 + 9; n++) begin
        din = (n < 8) ? pat[7-n] : 1'b0;
        @(negedge clk);
        if (n + 1 >= LAT0 + 9 && n + 1 < LAT0 + 9 + 8)
          got = (got << 1) | int'(dout);
      end
      din = 1'b0;
      chk(got == int'(pat), "R3 stream shape", got, int'(pat));
    end

    // R6: steady high stream, inhibit for one edge
    tap_code = '0;
    din = 1'b1;
    idle(6);
    chk(dout == 1'b1, "R6 stream passes", dout, 1);
    inhibit = 1'b1;
    @(negedge clk);
    chk(dout == 1'b0, "R6 inhibit forces low", dout, 0);
    inhibit = 1'b0;
    @(negedge clk);
    chk(dout == 1'b1, "R6 release resumes", dout, 1);
    din = 1'b0;
    idle(6);

    // R1: reset while a pulse is in flight clears it
    begin
      int seen;
      seen = 0;
      tap_code = 7'd50;
      idle(140);
      din = 1'b1;
      @(negedge clk);
      din = 1'b0;
      idle(20);
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      for (int n = 0; n < 140; n++) begin
        @(negedge clk);
        if (dout) seen++;
      end
      chk(seen == 0, "R1 reset empties line", seen, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule